// File: doc/BRIEF.md
# Trigger-Latency Sample Store with Frame Readout

This block sits behind the digitisers of one 25-crystal readout tower. On every bunch-crossing clock it writes one 14-bit word per channel into a circular buffer of 256 positions. Each word holds a 2-bit gain code above a 12-bit ADC value. The words stay in the buffer for the whole trigger latency. A free-running crossing counter provides the write position.

When a level-1 accept arrives, the block looks back by the programmed latency to find the triggered crossing and records that crossing as a pending event. Up to four events can wait in a queue. A readout state machine takes the events one at a time. For each event it sends a frame on a 16-bit bus: a header word, then ten consecutive crossings of all 25 channels, then a trailer word. An accept that arrives while the queue is full is dropped and sets a sticky overflow flag. A latency too long for a ten-crossing window raises a configuration error.

The readout machine has four states. IDLE waits for a pending event. IDLE→HEAD takes an event when the queue is not empty. HEAD→DATA always follows. DATA→DATA steps through the samples. DATA→TAIL follows the last channel of the last crossing. TAIL→HEAD takes the next event when one is pending. TAIL→IDLE is taken otherwise.

Top module: `l1_sample_store`

## Requirements
- R1: While reset is asserted, rd_valid, rd_sof, rd_eof and ovf are all 0.
- R2: The crossing counter starts at 0 on the first clock after reset is released and wraps modulo 4096. Each clock writes samp_in into buffer position (crossing mod 256). A later read of that position returns what was written, until the position is written again.
- R3: A frame is exactly 252 words on consecutive cycles with rd_valid high. rd_sof marks the first word and rd_eof the last. rd_valid is low between frames unless the next frame starts in the cycle right after rd_eof.
- R4: The header word carries the event number in bits [15:12] and the triggered crossing in bits [11:0]. The event number counts queued accepts modulo 16, and the first one is 0. The triggered crossing is (crossing at the accept − latency) mod 4096.
- R5: Data word j (j = 0..249) carries crossing offset j/25 from the triggered crossing and channel j mod 25. Its value is {2'b00, samp_in[14c+13:14c]}, read from the buffer during the cycle it is output.
- R6: The trailer word is 16'hE0FC, a 4'hE tag above the 12-bit frame length 252.
- R7: Accepts are served in arrival order. When the machine is idle, the header appears two cycles after the cycle in which l1a is high. When a frame ends with an event pending, the next header follows rd_eof in the next cycle.
- R8: An accept is dropped when 4 events are pending at its clock edge. Pending means queued and not yet started, and this test ignores a start in that same edge. A dropped accept does not advance the event number and sets ovf, which stays high until reset.
- R9: cfg_err is high exactly when latency + 10 > 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_in | input | 350 | 25 channels × {gain[1:0], adc[11:0]}, channel c at bits 14c+13:14c |
| latency | input | 8 | Trigger latency in crossings |
| l1a | input | 1 | Level-1 accept, one per high cycle |
| rd_data | output | 16 | Readout bus word |
| rd_valid | output | 1 | rd_data holds a frame word |
| rd_sof | output | 1 | Header word marker |
| rd_eof | output | 1 | Trailer word marker |
| cfg_err | output | 1 | Latency plus window exceeds buffer depth |
| ovf | output | 1 | Sticky accept-queue overflow |

## Verification
Two activities collide often in this block. One is the writing of the ring and the reading of a window. The other is the queuing of a new accept while a frame is being sent. The bench provokes both. It fires accepts back to back and in the middle of frames. It also uses latencies of 0 and 255, so the window being read overlaps the write position and is partly overwritten during readout. Each cycle the bench compares the bus against a behavioural model. The model keeps its own copy of the ring and a queue of pending events, and decides the outputs from the ring contents at the moment each word is read.

// File: rtl/l1ss_pkg.sv
package l1ss_pkg;
    localparam int SW  = 14;   // stored word: gain + adc
    localparam int BCW = 12;   // crossing counter width
    localparam int EVW = 4;    // event number width in header

    typedef struct packed {
        logic [EVW-1:0] evt;
        logic [BCW-1:0] bcn;
    } trig_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HEAD,
        ST_DATA,
        ST_TAIL
    } rd_state_t;
endpackage

// File: rtl/sample_ring.sv
module sample_ring
    import l1ss_pkg::*;
#(
    parameter int NCH   = 25,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NCH*SW-1:0]  wr_word,
    input  logic [AW-1:0]      rd_addr,
    output logic [NCH*SW-1:0]  rd_word,
    output logic [BCW-1:0]     bcn
);
    logic [NCH*SW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bcn <= '0;
        else        bcn <= bcn + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst_n) mem[bcn[AW-1:0]] <= wr_word;
    end

    assign rd_word = mem[rd_addr];
endmodule

// File: rtl/accept_fifo.sv
module accept_fifo #(
    parameter int W  = 16,
    parameter int QD = 4,
    localparam int QW = $clog2(QD)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    logic [W-1:0] slot [QD];
    logic [QW-1:0] wp, rp;
    logic [QW:0]   cnt;
    logic          push_ok, pop_ok;

    assign full    = (cnt == (QW+1)'(QD));
    assign empty   = (cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = slot[rp];

    always_ff @(posedge clk) begin
        if (push_ok) slot[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push_ok) wp <= wp + 1'b1;
            if (pop_ok)  rp <= rp + 1'b1;
            unique case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/readout_fsm.sv
module readout_fsm
    import l1ss_pkg::*;
#(
    parameter int NCH   = 25,
    parameter int WIN   = 10,
    parameter int AW    = 8,
    localparam int SIW  = $clog2(WIN),
    localparam int CIW  = $clog2(NCH),
    localparam int FRAME = 2 + NCH*WIN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pend,
    input  trig_t             head,
    input  logic [NCH*SW-1:0] rd_word,
    output logic              pop,
    output logic [AW-1:0]     rd_addr,
    output logic [15:0]       rd_data,
    output logic              rd_valid,
    output logic              rd_sof,
    output logic              rd_eof
);
    rd_state_t state, nxt;
    trig_t     cur;
    logic [SIW-1:0] s_idx;
    logic [CIW-1:0] c_idx;
    logic last_c, last_s;

    assign last_c  = (c_idx == CIW'(NCH-1));
    assign last_s  = (s_idx == SIW'(WIN-1));
    assign rd_addr = cur.bcn[AW-1:0] + AW'(s_idx);

    always_comb begin
        nxt = state;
        pop = 1'b0;
        unique case (state)
            ST_IDLE: if (pend) begin pop = 1'b1; nxt = ST_HEAD; end
            ST_HEAD: nxt = ST_DATA;
            ST_DATA: if (last_s && last_c) nxt = ST_TAIL;
            ST_TAIL: begin
                if (pend) begin pop = 1'b1; nxt = ST_HEAD; end
                else      nxt = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur   <= '0;
            s_idx <= '0;
            c_idx <= '0;
        end else begin
            if (pop) cur <= head;
            if (state == ST_HEAD) begin
                s_idx <= '0;
                c_idx <= '0;
            end else if (state == ST_DATA) begin
                if (last_c) begin
                    c_idx <= '0;
                    s_idx <= s_idx + 1'b1;
                end else begin
                    c_idx <= c_idx + 1'b1;
                end
            end
        end
    end

    always_comb begin
        rd_data  = '0;
        rd_valid = 1'b0;
        rd_sof   = 1'b0;
        rd_eof   = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_HEAD: begin
                rd_valid = 1'b1;
                rd_sof   = 1'b1;
                rd_data  = {cur.evt, cur.bcn};
            end
            ST_DATA: begin
                rd_valid = 1'b1;
                rd_data  = {2'b00, rd_word[int'(c_idx)*SW +: SW]};
            end
            ST_TAIL: begin
                rd_valid = 1'b1;
                rd_eof   = 1'b1;
                rd_data  = {4'hE, 12'(FRAME)};
            end
        endcase
    end
endmodule

// File: rtl/l1_sample_store.sv
module l1_sample_store
    import l1ss_pkg::*;
#(
    parameter int NCH   = 25,
    parameter int WIN   = 10,
    parameter int DEPTH = 256,
    parameter int QD    = 4,
    parameter int LW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH*SW-1:0] samp_in,
    input  logic [LW-1:0]     latency,
    input  logic              l1a,
    output logic [15:0]       rd_data,
    output logic              rd_valid,
    output logic              rd_sof,
    output logic              rd_eof,
    output logic              cfg_err,
    output logic              ovf
);
    logic [BCW-1:0]    bcn;
    logic [AW-1:0]     rd_addr;
    logic [NCH*SW-1:0] rd_word;
    logic [EVW-1:0]    evt_cnt;
    trig_t             new_trig, head;
    logic              q_empty, q_full, pop;

    assign cfg_err      = (int'(latency) + WIN > DEPTH);
    assign new_trig.evt = evt_cnt;
    assign new_trig.bcn = bcn - BCW'(latency);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_cnt <= '0;
            ovf     <= 1'b0;
        end else if (l1a) begin
            if (q_full) ovf     <= 1'b1;
            else        evt_cnt <= evt_cnt + 1'b1;
        end
    end

    sample_ring #(.NCH(NCH), .DEPTH(DEPTH)) u_ring (
        .clk(clk), .rst_n(rst_n), .wr_word(samp_in),
        .rd_addr(rd_addr), .rd_word(rd_word), .bcn(bcn)
    );

    accept_fifo #(.W($bits(trig_t)), .QD(QD)) u_q (
        .clk(clk), .rst_n(rst_n), .push(l1a), .pop(pop),
        .din(new_trig), .dout(head), .empty(q_empty), .full(q_full)
    );

    readout_fsm #(.NCH(NCH), .WIN(WIN), .AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .pend(!q_empty), .head(head),
        .rd_word(rd_word), .pop(pop), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .rd_sof(rd_sof), .rd_eof(rd_eof)
    );
endmodule

// File: rtl/l1_sample_store_chk.sv
module l1_sample_store_chk (
    input logic clk,
    input logic rst_n,
    input logic l1a,
    input logic rd_valid,
    input logic rd_sof,
    input logic rd_eof,
    input logic ovf
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> (!rd_valid && !ovf));

    assert_sof_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sof |-> rd_valid && !rd_eof);

    assert_frame_contig_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_eof) |=> rd_valid);

    assert_after_sof_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sof |=> (!rd_sof && !rd_eof));

    assert_eof_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_eof |=> (rd_sof || !rd_valid));

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    assert_ovf_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(l1a));
endmodule

bind l1_sample_store l1_sample_store_chk u_chk (
    .clk(clk), .rst_n(rst_n), .l1a(l1a), .rd_valid(rd_valid),
    .rd_sof(rd_sof), .rd_eof(rd_eof), .ovf(ovf)
);

// File: tb/l1_sample_store_test.sv
module l1_sample_store_test;
    localparam int NCH = 25;
    localparam int FRM = 252;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH*14-1:0] samp_in = '0;
    logic [7:0]        latency = 8'd100;
    logic              l1a = 1'b0;
    logic [15:0]       rd_data;
    logic              rd_valid, rd_sof, rd_eof, cfg_err, ovf;

    always #2.5 clk = ~clk;

    l1_sample_store uut (
        .clk(clk), .rst_n(rst_n), .samp_in(samp_in), .latency(latency),
        .l1a(l1a), .rd_data(rd_data), .rd_valid(rd_valid), .rd_sof(rd_sof),
        .rd_eof(rd_eof), .cfg_err(cfg_err), .ovf(ovf)
    );

    int checks = 0;
    int bad = 0;
    bit finished = 0;

    // behavioural reference model
    logic [NCH*14-1:0] mm [256];
    int m_bcn, m_evt, m_k, m_start, m_hdr;
    bit m_active, m_ovf;
    int q_bcn[$];
    int q_evt[$];
    int accepted = 0;
    int frames_seen = 0;
    int cyc = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_bcn = 0; m_evt = 0; m_k = 0; m_active = 0; m_ovf = 0;
            q_bcn.delete(); q_evt.delete();
        end else begin
            bit full;
            full = (q_bcn.size() == 4);
            if (m_active && m_k < FRM-1) m_k++;
            else if (q_bcn.size() > 0) begin
                int tb, te;
                tb = q_bcn.pop_front();
                te = q_evt.pop_front();
                m_active = 1; m_k = 0;
                m_start = tb % 256;
                m_hdr = ((te % 16) << 12) | tb;
            end else m_active = 0;
            if (l1a) begin
                if (full) m_ovf = 1;
                else begin
                    q_bcn.push_back((m_bcn - int'(latency) + 4096) % 4096);
                    q_evt.push_back(m_evt);
                    m_evt++;
                    accepted++;
                end
            end
            mm[m_bcn % 256] = samp_in;
            m_bcn = (m_bcn + 1) % 4096;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at t=%0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit ev, es, ee;
            int ed;
            ev = m_active;
            es = m_active && m_k == 0;
            ee = m_active && m_k == FRM-1;
            chk(rd_valid == ev, "R3 R7 valid", rd_valid, ev);
            chk(rd_sof == es, "R3 sof", rd_sof, es);
            chk(rd_eof == ee, "R3 eof", rd_eof, ee);
            if (ev) begin
                if (m_k == 0) begin
                    ed = m_hdr;
                    chk(rd_data == 16'(ed), "R4 header", rd_data, ed);
                end else if (m_k == FRM-1) begin
                    ed = 16'hE0FC;
                    chk(rd_data == 16'(ed), "R6 trailer", rd_data, ed);
                    frames_seen++;
                end else begin
                    int j, s, c;
                    logic [NCH*14-1:0] w;
                    j = m_k - 1; s = j / NCH; c = j % NCH;
                    w = mm[(m_start + s) % 256];
                    ed = int'(w[c*14 +: 14]);
                    chk(rd_data == 16'(ed), "R5 R2 data", rd_data, ed);
                end
            end
            chk(ovf == m_ovf, "R8 ovf", ovf, m_ovf);
            ed = (int'(latency) + 10 > 256) ? 1 : 0;
            chk(cfg_err == ed[0], "R9 cfg_err", cfg_err, ed);
        end
    end

    // sample stimulus
    always @(posedge clk) begin
        #1;
        cyc++;
        for (int c = 0; c < NCH; c++)
            samp_in[c*14 +: 14] <= 14'(cyc*37 + c*1237 + (cyc >> 3) * c);
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic fire;
        l1a = 1'b1;
        step(1);
        l1a = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            finished = 1;
            bad++; checks++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        step(3);
        // R1: outputs quiet in reset
        chk(!rd_valid && !rd_sof && !rd_eof, "R1 reset outputs", rd_valid, 0);
        chk(!ovf, "R1 reset ovf", ovf, 0);
        rst_n = 1'b1;
        step(300);
        // single accept from idle
        fire(); step(300);
        // second accept lands during an ongoing frame
        fire(); step(100); fire(); step(600);
        // burst beyond queue capacity: R8 overflow
        repeat (7) fire();
        step(1700);
        // short latency, two accepts one apart (trailer to header hand-off)
        latency = 8'd5;
        fire(); step(1); fire(); step(600);
        // configuration edges R9
        latency = 8'd246; step(3);
        latency = 8'd247; step(3);
        latency = 8'd255; fire(); step(400);
        latency = 8'd0;   fire(); step(400);
        chk(frames_seen == accepted, "R7 frames served", frames_seen, accepted);
        chk(ovf == 1'b1, "R8 ovf sticky at end", ovf, 1);
        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule